// File: doc/BRIEF.md
# Region Protection Checker

This block screens instruction fetches and data accesses against a programmable set of address windows. There is one set of windows for the fetch side and a separate set for the data side. Each window is a naturally aligned power-of-two span. A window is described by an enable bit, a 5-bit size exponent and a base address. A 4-bit permission code per window says which of privileged and user mode may read or write it. Per-window mask bits give the cacheable attribute on both sides and the bufferable attribute on the data side.

Software fills the configuration through a small write-only register port. Each side presents a request strobe with an address, a privilege flag and, on the data side only, a write flag. Exactly one clock later the block returns a registered verdict: a response strobe, an abort flag and the memory attributes. When several enabled windows cover an address, the highest-numbered window decides. This lets window 0 serve as a catch-all background. A global enable bit switches checking on. While it is off, every access passes and carries no attributes.

Top module: `prot_checker`

## Requirements
- R1: A window register holds the enable in bit 0, the size code in bits [5:1] and the base in the upper bits. A code c gives a window of 2^(c+1) bytes, so 5'b01011 means 4 KB and 5'b11111 means 4 GB. A window with its enable clear, or with a code below 5'b01011, never matches.
- R2: Matching compares only the address bits above the window size. Any base bits below the window size are ignored.
- R3: When several enabled windows match, the highest-numbered one supplies both the permission code and the attributes.
- R4: The permission code of window n sits in bits [4n+3:4n] of its side's permission word, with these meanings:
  - 4'b0000 denies everything.
  - 4'b0001 lets privileged mode read and write, and aborts user mode.
  - 4'b0011 lets both modes read and write.
  - 4'b0110 lets both modes read and aborts every write.
- R5: Every other permission code aborts all accesses.
- R6: With checking enabled, an access that no enabled window matches aborts.
- R7: With the global enable clear, no access aborts, and cacheable and bufferable both read 0.
- R8: Cacheable comes from bit n of the side's cacheable mask, where n is the winning window. Bufferable comes from bit n of the data bufferable mask, and the fetch side has no bufferable output. An aborted access reports both attributes as 0.
- R9: The fetch side and the data side use only their own window registers and permission words. An instruction fetch is checked as a read.
- R10: The response strobe and verdict appear on the first clock edge after the request strobe. In a cycle with no response, the abort and attribute outputs read 0.
- R11: The configuration write addresses are as follows:
  - 0..7 are the fetch windows 0..7.
  - 8..15 are the data windows 0..7.
  - 16 is the fetch cacheable mask, in wdata[7:0].
  - 17 is the data cacheable mask, in wdata[7:0].
  - 18 is the data bufferable mask, in wdata[7:0].
  - 19 is the fetch permission word.
  - 20 is the data permission word.
  - 21 is the control register, with the global enable in bit 0.
  
  Writes to addresses 22..31 change nothing.
- R12: Reset clears the whole configuration, which disables checking, and clears all response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| i_req_valid | input | 1 | Fetch request strobe |
| i_addr | input | 32 | Fetch address |
| i_priv | input | 1 | Fetch is privileged |
| d_req_valid | input | 1 | Data request strobe |
| d_addr | input | 32 | Data address |
| d_priv | input | 1 | Data access is privileged |
| d_write | input | 1 | Data access is a write |
| i_rsp_valid | output | 1 | Fetch verdict valid |
| i_abort | output | 1 | Fetch aborts |
| i_cacheable | output | 1 | Fetch is cacheable |
| d_rsp_valid | output | 1 | Data verdict valid |
| d_abort | output | 1 | Data access aborts |
| d_cacheable | output | 1 | Data access is cacheable |
| d_bufferable | output | 1 | Data access is bufferable |

## Verification
Every verdict is due exactly one clock edge after its request strobe. The bench drives a request on a falling edge and reads the verdict on the next falling edge, after the single register stage. It then drops the strobe and checks on the following falling edge that the outputs are quiet.

A configuration write takes effect at the edge that samples it. A request driven on the falling edge after that write therefore sees the new setting.

// File: rtl/prot_pkg.sv
package prot_pkg;

    localparam int unsigned ADDR_W = 32;
    localparam logic [4:0]  MIN_SIZE_CODE = 5'd11;

    typedef struct packed {
        logic abort;
        logic cacheable;
        logic bufferable;
    } verdict_t;

    typedef struct packed {
        logic     valid;
        verdict_t v;
    } rsp_t;

    // Decode of a 4-bit permission code; unknown codes deny.
    function automatic logic perm_allows(input logic [3:0] code,
                                         input logic priv,
                                         input logic write);
        case (code)
            4'b0001: return priv;
            4'b0011: return 1'b1;
            4'b0110: return !write;
            default: return 1'b0;
        endcase
    endfunction

    // A window hits when enabled, legal in size and equal above its size.
    function automatic logic window_hit(input logic [ADDR_W-1:0] win,
                                        input logic [ADDR_W-1:0] addr);
        logic [5:0]        shift;
        logic [ADDR_W:0]   keep;
        if (!win[0] || win[5:1] < MIN_SIZE_CODE) return 1'b0;
        shift = {1'b0, win[5:1]} + 6'd1;
        keep  = {(ADDR_W+1){1'b1}} << shift;
        return ((addr ^ win) & keep[ADDR_W-1:0]) == '0;
    endfunction

endpackage

// File: rtl/prot_cfg.sv
module prot_cfg
    import prot_pkg::*;
#(
    parameter int unsigned N_WIN      = 8,
    parameter int unsigned CFG_ADDR_W = $clog2(2*N_WIN + 6)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [CFG_ADDR_W-1:0]         cfg_addr,
    input  logic [31:0]                   cfg_wdata,
    output logic [N_WIN-1:0][ADDR_W-1:0]  i_wins,
    output logic [N_WIN-1:0][ADDR_W-1:0]  d_wins,
    output logic [N_WIN-1:0]              i_cache_mask,
    output logic [N_WIN-1:0]              d_cache_mask,
    output logic [N_WIN-1:0]              d_buf_mask,
    output logic [4*N_WIN-1:0]            i_perm,
    output logic [4*N_WIN-1:0]            d_perm,
    output logic                          prot_en
);
    localparam logic [CFG_ADDR_W-1:0] A_ICACHE = CFG_ADDR_W'(2*N_WIN);
    localparam logic [CFG_ADDR_W-1:0] A_DCACHE = CFG_ADDR_W'(2*N_WIN + 1);
    localparam logic [CFG_ADDR_W-1:0] A_DBUF   = CFG_ADDR_W'(2*N_WIN + 2);
    localparam logic [CFG_ADDR_W-1:0] A_IPERM  = CFG_ADDR_W'(2*N_WIN + 3);
    localparam logic [CFG_ADDR_W-1:0] A_DPERM  = CFG_ADDR_W'(2*N_WIN + 4);
    localparam logic [CFG_ADDR_W-1:0] A_CTRL   = CFG_ADDR_W'(2*N_WIN + 5);

    typedef struct packed {
        logic [N_WIN-1:0][ADDR_W-1:0] i_wins;
        logic [N_WIN-1:0][ADDR_W-1:0] d_wins;
        logic [N_WIN-1:0]             i_cache;
        logic [N_WIN-1:0]             d_cache;
        logic [N_WIN-1:0]             d_buf;
        logic [4*N_WIN-1:0]           i_perm;
        logic [4*N_WIN-1:0]           d_perm;
        logic                         en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            for (int n = 0; n < int'(N_WIN); n++) begin
                if (cfg_addr == CFG_ADDR_W'(n))         cfg_d.i_wins[n] = cfg_wdata;
                if (cfg_addr == CFG_ADDR_W'(n + N_WIN)) cfg_d.d_wins[n] = cfg_wdata;
            end
            if (cfg_addr == A_ICACHE) cfg_d.i_cache = cfg_wdata[N_WIN-1:0];
            if (cfg_addr == A_DCACHE) cfg_d.d_cache = cfg_wdata[N_WIN-1:0];
            if (cfg_addr == A_DBUF)   cfg_d.d_buf   = cfg_wdata[N_WIN-1:0];
            if (cfg_addr == A_IPERM)  cfg_d.i_perm  = cfg_wdata[4*N_WIN-1:0];
            if (cfg_addr == A_DPERM)  cfg_d.d_perm  = cfg_wdata[4*N_WIN-1:0];
            if (cfg_addr == A_CTRL)   cfg_d.en      = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign i_wins       = cfg_q.i_wins;
    assign d_wins       = cfg_q.d_wins;
    assign i_cache_mask = cfg_q.i_cache;
    assign d_cache_mask = cfg_q.d_cache;
    assign d_buf_mask   = cfg_q.d_buf;
    assign i_perm       = cfg_q.i_perm;
    assign d_perm       = cfg_q.d_perm;
    assign prot_en      = cfg_q.en;

    // R11: writes outside the map leave the configuration untouched
    assert_unmapped_write_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > A_CTRL) |=> $stable(cfg_q));

endmodule

// File: rtl/prot_lookup.sv
module prot_lookup
    import prot_pkg::*;
#(
    parameter int unsigned N_WIN = 8,
    localparam int unsigned IDX_W = $clog2(N_WIN)
) (
    input  logic [N_WIN-1:0][ADDR_W-1:0] wins,
    input  logic [N_WIN-1:0]             cache_mask,
    input  logic [N_WIN-1:0]             buf_mask,
    input  logic [4*N_WIN-1:0]           perm,
    input  logic                         prot_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         priv,
    input  logic                         write,
    output verdict_t                     verdict
);
    logic             hit;
    logic [IDX_W-1:0] win_idx;
    logic [3:0]       code;
    logic             allowed;

    // Later windows overwrite earlier ones: highest-numbered hit wins.
    always_comb begin
        hit     = 1'b0;
        win_idx = '0;
        for (int n = 0; n < int'(N_WIN); n++) begin
            if (window_hit(wins[n], addr)) begin
                hit     = 1'b1;
                win_idx = IDX_W'(n);
            end
        end
    end

    always_comb begin
        code    = perm[{win_idx, 2'b00} +: 4];
        allowed = hit && perm_allows(code, priv, write);
        verdict = '0;
        if (prot_en) begin
            if (!allowed) begin
                verdict.abort = 1'b1;
            end else begin
                verdict.cacheable  = cache_mask[win_idx];
                verdict.bufferable = buf_mask[win_idx];
            end
        end
    end

endmodule

// File: rtl/prot_checker.sv
module prot_checker
    import prot_pkg::*;
#(
    parameter int unsigned N_WIN      = 8,
    parameter int unsigned CFG_ADDR_W = $clog2(2*N_WIN + 6)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]            cfg_wdata,
    input  logic                   i_req_valid,
    input  logic [ADDR_W-1:0]      i_addr,
    input  logic                   i_priv,
    input  logic                   d_req_valid,
    input  logic [ADDR_W-1:0]      d_addr,
    input  logic                   d_priv,
    input  logic                   d_write,
    output logic                   i_rsp_valid,
    output logic                   i_abort,
    output logic                   i_cacheable,
    output logic                   d_rsp_valid,
    output logic                   d_abort,
    output logic                   d_cacheable,
    output logic                   d_bufferable
);
    logic [N_WIN-1:0][ADDR_W-1:0] i_wins, d_wins;
    logic [N_WIN-1:0]             i_cache_mask, d_cache_mask, d_buf_mask;
    logic [4*N_WIN-1:0]           i_perm, d_perm;
    logic                         prot_en;
    verdict_t                     i_verd, d_verd;

    typedef struct packed {
        rsp_t i;
        rsp_t d;
    } state_t;

    state_t st_d, st_q;

    prot_cfg #(.N_WIN(N_WIN), .CFG_ADDR_W(CFG_ADDR_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .i_wins       (i_wins),
        .d_wins       (d_wins),
        .i_cache_mask (i_cache_mask),
        .d_cache_mask (d_cache_mask),
        .d_buf_mask   (d_buf_mask),
        .i_perm       (i_perm),
        .d_perm       (d_perm),
        .prot_en      (prot_en)
    );

    // Fetch side: always a read, no bufferable attribute.
    prot_lookup #(.N_WIN(N_WIN)) u_i_lookup (
        .wins       (i_wins),
        .cache_mask (i_cache_mask),
        .buf_mask   ('0),
        .perm       (i_perm),
        .prot_en    (prot_en),
        .addr       (i_addr),
        .priv       (i_priv),
        .write      (1'b0),
        .verdict    (i_verd)
    );

    prot_lookup #(.N_WIN(N_WIN)) u_d_lookup (
        .wins       (d_wins),
        .cache_mask (d_cache_mask),
        .buf_mask   (d_buf_mask),
        .perm       (d_perm),
        .prot_en    (prot_en),
        .addr       (d_addr),
        .priv       (d_priv),
        .write      (d_write),
        .verdict    (d_verd)
    );

    always_comb begin
        st_d.i.valid = i_req_valid;
        st_d.i.v     = i_req_valid ? i_verd : '0;
        st_d.d.valid = d_req_valid;
        st_d.d.v     = d_req_valid ? d_verd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign i_rsp_valid  = st_q.i.valid;
    assign i_abort      = st_q.i.v.abort;
    assign i_cacheable  = st_q.i.v.cacheable;
    assign d_rsp_valid  = st_q.d.valid;
    assign d_abort      = st_q.d.v.abort;
    assign d_cacheable  = st_q.d.v.cacheable;
    assign d_bufferable = st_q.d.v.bufferable;

    // R10: a data request is answered on the next edge
    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        d_req_valid |=> d_rsp_valid);

    // R10: outputs are quiet without a response
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !i_rsp_valid |-> (!i_abort && !i_cacheable));

    // R7: with checking off, a request comes back clean
    assert_disabled_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req_valid && !prot_en) |=> (!d_abort && !d_cacheable && !d_bufferable));

    // R8: an aborted access carries no attributes
    assert_abort_no_attr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        d_abort |-> (!d_cacheable && !d_bufferable));

endmodule

// File: tb/test_prot_checker.sv
module test_prot_checker;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        i_req_valid = 1'b0, i_priv = 1'b0;
    logic [31:0] i_addr = '0;
    logic        d_req_valid = 1'b0, d_priv = 1'b0, d_write = 1'b0;
    logic [31:0] d_addr = '0;
    logic        i_rsp_valid, i_abort, i_cacheable;
    logic        d_rsp_valid, d_abort, d_cacheable, d_bufferable;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench copy of the configuration, kept from the writes it issues.
    logic [31:0] m_win [2][NW];
    logic [7:0]  m_cache [2];
    logic [7:0]  m_buf;
    logic [31:0] m_perm [2];
    logic        m_en;

    prot_checker i_prot_checker (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .i_req_valid(i_req_valid), .i_addr(i_addr), .i_priv(i_priv),
        .d_req_valid(d_req_valid), .d_addr(d_addr), .d_priv(d_priv), .d_write(d_write),
        .i_rsp_valid(i_rsp_valid), .i_abort(i_abort), .i_cacheable(i_cacheable),
        .d_rsp_valid(d_rsp_valid), .d_abort(d_abort), .d_cacheable(d_cacheable),
        .d_bufferable(d_bufferable)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] size_mask(input logic [4:0] code);
        if (code == 5'd31) return 32'h0;
        return ~((32'h1 << (code + 1)) - 32'h1);
    endfunction

    // Expected {abort, cacheable, bufferable} for one side (0 fetch, 1 data).
    function automatic logic [2:0] expect_verdict(input int side, input logic [31:0] a,
                                                  input logic pv, input logic wr);
        int winner = -1;
        logic [3:0] pc;
        logic ok;
        if (!m_en) return 3'b000;
        for (int n = 0; n < NW; n++) begin
            logic [31:0] w = m_win[side][n];
            if (w[0] && w[5:1] >= 5'd11 && ((a & size_mask(w[5:1])) == (w & size_mask(w[5:1]))))
                winner = n;
        end
        if (winner < 0) return 3'b100;
        pc = m_perm[side][winner*4 +: 4];
        if (pc == 4'b0011)      ok = 1'b1;
        else if (pc == 4'b0001) ok = pv;
        else if (pc == 4'b0110) ok = !wr;
        else                    ok = 1'b0;
        if (!ok) return 3'b100;
        return {1'b0, m_cache[side][winner], (side == 1) ? m_buf[winner] : 1'b0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 5'd8)        m_win[0][a] = v;
        else if (a < 5'd16)  m_win[1][a - 5'd8] = v;
        else if (a == 5'd16) m_cache[0] = v[7:0];
        else if (a == 5'd17) m_cache[1] = v[7:0];
        else if (a == 5'd18) m_buf = v[7:0];
        else if (a == 5'd19) m_perm[0] = v;
        else if (a == 5'd20) m_perm[1] = v;
        else if (a == 5'd21) m_en = v[0];
    endtask

    // Request on a falling edge, verdict read on the next falling edge.
    task automatic access(input logic [31:0] ia, input logic ip,
                          input logic [31:0] da, input logic dp, input logic dw,
                          input string req);
        logic [2:0] ei, ed;
        @(negedge clk);
        i_req_valid = 1'b1; i_addr = ia; i_priv = ip;
        d_req_valid = 1'b1; d_addr = da; d_priv = dp; d_write = dw;
        ei = expect_verdict(0, ia, ip, 1'b0);
        ed = expect_verdict(1, da, dp, dw);
        @(negedge clk);
        check(i_rsp_valid && {i_abort, i_cacheable} == ei[2:1], {req, " fetch"},
              {29'd0, i_rsp_valid, i_abort, i_cacheable}, {29'd0, 1'b1, ei[2:1]});
        check(d_rsp_valid && {d_abort, d_cacheable, d_bufferable} == ed, {req, " data"},
              {28'd0, d_rsp_valid, d_abort, d_cacheable, d_bufferable}, {28'd0, 1'b1, ed});
        i_req_valid = 1'b0; d_req_valid = 1'b0;
    endtask

    task automatic idle_check();
        @(negedge clk);
        check(!i_rsp_valid && !i_abort && !i_cacheable && !d_rsp_valid && !d_abort &&
              !d_cacheable && !d_bufferable, "R10 quiet without request",
              {25'd0, i_rsp_valid, i_abort, i_cacheable, d_rsp_valid, d_abort, d_cacheable,
               d_bufferable}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int s = 0; s < 2; s++) begin
            for (int n = 0; n < NW; n++) m_win[s][n] = '0;
            m_cache[s] = '0; m_perm[s] = '0;
        end
        m_buf = '0; m_en = 1'b0;

        repeat (3) @(negedge clk);
        // R12: reset state
        check(!i_rsp_valid && !d_rsp_valid && !d_abort && !i_abort, "R12 reset outputs",
              {30'd0, i_rsp_valid, d_rsp_valid}, 32'd0);
        rst_n = 1'b1;
        // R12: cleared configuration means checking is off
        access(32'h1234_0000, 1'b0, 32'h8000_0000, 1'b0, 1'b1, "R12 disabled after reset");

        // Data side: background, RAM, IO, ROM windows (R9 differs from fetch side).
        cfg_write(5'd8,  32'h0000_0000 | (5'd31 << 1) | 1);
        cfg_write(5'd9,  32'h0000_0000 | (5'd17 << 1) | 1);
        cfg_write(5'd11, 32'h1000_0000 | (5'd27 << 1) | 1);
        cfg_write(5'd12, 32'h2400_0000 | (5'd24 << 1) | 1);
        cfg_write(5'd20, 32'h0006_1030);
        cfg_write(5'd17, 32'h0000_0012);
        cfg_write(5'd18, 32'h0000_0002);
        // Fetch side: RAM window only, cached.
        cfg_write(5'd1, 32'h0000_0000 | (5'd17 << 1) | 1);
        cfg_write(5'd19, 32'h0000_0030);
        cfg_write(5'd16, 32'h0000_0002);
        // R7: configured but still disabled -> no abort, no attributes
        access(32'h0000_0100, 1'b0, 32'h0000_0100, 1'b0, 1'b1, "R7 disabled pass");
        cfg_write(5'd21, 32'h1);

        // R3: RAM window overrides background; R8 attributes
        access(32'h0000_0100, 1'b0, 32'h0000_0100, 1'b0, 1'b1, "R3 R8 ram window");
        // R4 deny code on background; R6 fetch side with no match
        access(32'h0005_0000, 1'b1, 32'h0005_0000, 1'b1, 1'b0, "R4 R6 background deny");
        // R4 privileged-only IO window
        access(32'h0000_0000, 1'b0, 32'h1000_0010, 1'b0, 1'b0, "R4 io user");
        access(32'h0000_0000, 1'b1, 32'h1000_0010, 1'b1, 1'b1, "R4 io priv");
        // R4 read-only ROM window; R8 cacheable without bufferable
        access(32'h0000_0000, 1'b0, 32'h2500_0000, 1'b0, 1'b1, "R4 rom write");
        access(32'h0000_0000, 1'b0, 32'h25FF_FFFC, 1'b0, 1'b0, "R4 R8 rom read");
        // R5: unknown code 4'b0111 on data window 5
        cfg_write(5'd13, 32'h5000_0000 | (5'd12 << 1) | 1);
        cfg_write(5'd20, 32'h0076_1030);
        access(32'h0000_0000, 1'b1, 32'h5000_0004, 1'b1, 1'b0, "R5 unknown code");
        // R1: code below 4 KB never matches (fetch window 6)
        cfg_write(5'd6, 32'h3000_0000 | (5'd10 << 1) | 1);
        cfg_write(5'd19, 32'h0300_0030);
        access(32'h3000_0000, 1'b1, 32'h0, 1'b0, 1'b0, "R1 illegal size code");
        // R1 enable bit clear: no match
        cfg_write(5'd6, 32'h3000_0000 | (5'd12 << 1));
        access(32'h3000_0000, 1'b1, 32'h0, 1'b0, 1'b0, "R1 window disabled");
        // R2: base bits below the size are ignored
        cfg_write(5'd6, 32'h3000_1F00 | (5'd15 << 1) | 1);
        access(32'h3000_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R2 low base bits ignored");
        access(32'h3001_0000, 1'b0, 32'h0, 1'b0, 1'b0, "R2 just past window");
        // R11: writes to unmapped addresses change nothing
        for (int a = 22; a < 32; a++) begin
            @(negedge clk);
            cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 32'h0;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        access(32'h3000_0000, 1'b0, 32'h0000_0100, 1'b0, 1'b1, "R11 unmapped writes");
        idle_check();

        // R9 R3 R4 R8 R10: random windows and accesses against the model
        for (int it = 0; it < 400; it++) begin
            if (it % 40 == 0) begin
                for (int a = 0; a < 16; a++) begin
                    logic [4:0] code = 5'(11 + $urandom % 21);
                    logic [31:0] base = $urandom & size_mask(code);
                    cfg_write(5'(a), base | (32'(code) << 1) | 32'(($urandom % 4) != 0));
                end
                for (int a = 16; a < 21; a++) begin
                    logic [31:0] pw = '0;
                    if (a < 19) pw = $urandom;
                    else for (int n = 0; n < NW; n++) begin
                        int sel = $urandom % 5;
                        pw[n*4 +: 4] = (sel == 0) ? 4'h0 : (sel == 1) ? 4'h1 :
                                       (sel == 2) ? 4'h3 : (sel == 3) ? 4'h6 : 4'($urandom);
                    end
                    cfg_write(5'(a), pw);
                end
                cfg_write(5'd21, 32'(($urandom % 6) != 0));
            end
            begin
                logic [31:0] ia = $urandom, da = $urandom;
                if ($urandom % 3 != 0) ia = (m_win[0][$urandom % NW] & 32'hFFFF_F000) | ($urandom & 32'hFFF);
                if ($urandom % 3 != 0) da = (m_win[1][$urandom % NW] & 32'hFFFF_F000) | ($urandom & 32'hFFF);
                access(ia, 1'($urandom), da, 1'($urandom), 1'($urandom), "R9 random");
            end
            if (it % 50 == 0) idle_check();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule